// File: doc/BRIEF.md
# Host/Local Command Mailbox Pair

This block holds two one-byte mailboxes that carry urgent command bytes between an external host and a local processor without going through any queue. The inbound mailbox is written by the host and read by the local processor. The outbound mailbox is written by the local processor and read by the host. Each mailbox shows whether it holds a byte, and both sides see that status. A write raises an interrupt towards the receiving side. The receiver's read empties the mailbox and drops that interrupt.

Each mailbox is a two-state machine with states `MB_EMPTY` and `MB_FULL`. It has these transitions:

- **fill**: `MB_EMPTY` to `MB_FULL` on a write.
- **drain**: `MB_FULL` to `MB_EMPTY` on a read with no write in the same cycle.
- **refill**: `MB_FULL` stays in `MB_FULL` on a write and a read in the same cycle. The new byte is taken.
- **reject**: `MB_FULL` stays in `MB_FULL` on a write with no read. The byte is dropped and the writer's overwrite flag is set.

A freeze input locks the host out while the local side reconfigures. During freeze, host writes to the inbound mailbox and to the host control bit are discarded, and a sticky host error flag records the attempt. The host control bit enables the host interrupt for the outbound mailbox.

Top module: `cmd_mailbox_pair`

## Requirements
- R1: After reset both mailboxes are empty, `h_out_empty` is 1, both interrupts are 0, all error flags are 0 and the host interrupt enable is 0.
- R2: A host write to the empty inbound mailbox while not frozen makes `l_in_full`, `h_in_full` and `l_irq` 1 after the next clock edge, with `l_in_data` showing the byte.
- R3: A local read (`l_in_rd`) of a full inbound mailbox with no host write in that cycle makes `l_in_full`, `h_in_full` and `l_irq` 0 after the next edge, all in the same cycle.
- R4: A local write to the empty outbound mailbox makes `l_out_full` 1 and `h_out_empty` 0 after the next edge, with `h_out_data` showing the byte. Host-side encoding: 1 means empty, 0 means a command is present.
- R5: A host read (`h_out_rd`) of a full outbound mailbox with no local write in that cycle makes `l_out_full` 0, `h_out_empty` 1 and `h_irq` 0 after the next edge.
- R6: A write to a full mailbox with no read in the same cycle keeps the stored byte. It sets the writer's sticky overwrite flag: `h_ovr_err` for inbound, `l_ovr_err` for outbound.
- R7: A write and a read of a full mailbox in the same cycle store the new byte. The mailbox stays full and no overwrite flag is set.
- R8: While `freeze` is 1, a host inbound write leaves the inbound mailbox unchanged and sets `h_freeze_err`.
- R9: While `freeze` is 1, a host control write leaves the interrupt enable unchanged and sets `h_freeze_err`.
- R10: Each error flag holds until its side's status read pulse: `h_stat_rd` clears `h_ovr_err` and `h_freeze_err`, and `l_stat_rd` clears `l_ovr_err`. A new setting event in the same cycle as the clear wins, and the flag stays 1.
- R11: `h_ctl_wr` loads `h_ctl_irq_en` into the enable when not frozen. `h_irq` is 1 exactly when the outbound mailbox is full and the enable is 1.
- R12: A read of an empty mailbox changes no status, interrupt or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Blocks host writes to the inbound mailbox and to the control bit |
| h_in_wr | input | 1 | Host write strobe, inbound mailbox |
| h_in_wdata | input | 8 | Host write byte |
| h_out_rd | input | 1 | Host read strobe, outbound mailbox |
| h_out_data | output | 8 | Outbound byte as seen by the host |
| h_out_empty | output | 1 | 1 = outbound empty, 0 = command present |
| h_in_full | output | 1 | Inbound full, host view |
| h_ctl_wr | input | 1 | Host control write strobe |
| h_ctl_irq_en | input | 1 | Value written to the host interrupt enable |
| h_stat_rd | input | 1 | Host status read pulse; clears host flags |
| h_ovr_err | output | 1 | Sticky: host wrote a full inbound mailbox |
| h_freeze_err | output | 1 | Sticky: host write attempted during freeze |
| h_irq | output | 1 | Host interrupt: outbound full and enabled |
| l_in_rd | input | 1 | Local read strobe, inbound mailbox |
| l_in_data | output | 8 | Inbound byte as seen locally |
| l_in_full | output | 1 | Inbound full, local view |
| l_irq | output | 1 | Local interrupt: inbound full |
| l_out_wr | input | 1 | Local write strobe, outbound mailbox |
| l_out_wdata | input | 8 | Local write byte |
| l_out_full | output | 1 | Outbound full, local view |
| l_stat_rd | input | 1 | Local status read pulse; clears local flag |
| l_ovr_err | output | 1 | Sticky: local side wrote a full outbound mailbox |

## Verification
Two pairs of events can land in the same clock cycle.

- **Write and read of one full mailbox.** The bench provokes this on both mailboxes by asserting the write and the read strobes together. The refill transition is judged by the new byte appearing with the full status still set and no overwrite flag.
- **A flag's clear and a new setting event.** The bench pulses the host status read in the same cycle as a frozen host write. It expects `h_freeze_err` to stay 1 rather than fall.

Every step is compared against a model built from the requirements, one cycle after the edge that takes the inputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mb_state_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_H_OVR = 0;
    localparam int FLAG_H_FRZ = 1;
    localparam int FLAG_L_OVR = 2;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic         full,
    output logic [W-1:0] data,
    output logic         ovr_hit
);
    mb_state_e state_q, state_d;
    logic      take;

    // Next-state decode: fill, drain, refill, reject
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            MB_EMPTY: begin
                if (wr) begin
                    state_d = MB_FULL;
                    take    = 1'b1;
                end
            end
            MB_FULL: begin
                if (wr && rd) begin
                    take = 1'b1;
                end else if (rd) begin
                    state_d = MB_EMPTY;
                end
            end
            default: state_d = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (take) data <= wr_data;
    end

    // Outputs
    always_comb begin
        full    = (state_q == MB_FULL);
        ovr_hit = (state_q == MB_FULL) && wr && !rd;
    end

    a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && wr) |=> (full && data == $past(wr_data)));
    a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd && !wr) |=> !full);
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> (full && $stable(data)));
    a_r7_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && rd) |=> (full && data == $past(wr_data)));
    a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && rd && !wr) |=> !full);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic wr,
    input  logic din,
    output logic en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= 1'b0;
        else if (wr && !freeze) en_q <= din;
    end

    a_r9_frozen_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && wr) |=> $stable(en_q));
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && wr) |=> (en_q == $past(din)));
endmodule

// File: rtl/cmd_mailbox_pair.sv
module cmd_mailbox_pair
    import mbox_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         h_in_wr,
    input  logic [W-1:0] h_in_wdata,
    input  logic         h_out_rd,
    output logic [W-1:0] h_out_data,
    output logic         h_out_empty,
    output logic         h_in_full,
    input  logic         h_ctl_wr,
    input  logic         h_ctl_irq_en,
    input  logic         h_stat_rd,
    output logic         h_ovr_err,
    output logic         h_freeze_err,
    output logic         h_irq,
    input  logic         l_in_rd,
    output logic [W-1:0] l_in_data,
    output logic         l_in_full,
    output logic         l_irq,
    input  logic         l_out_wr,
    input  logic [W-1:0] l_out_wdata,
    output logic         l_out_full,
    input  logic         l_stat_rd,
    output logic         l_ovr_err
);
    logic              in_wr_ok;
    logic              in_full, out_full;
    logic              in_ovr, out_ovr;
    logic              irq_en;
    logic [FLAG_N-1:0] fl_set, fl_clr, fl_q;

    assign in_wr_ok = h_in_wr && !freeze;

    mbox_slot #(.W(W)) u_inbox (
        .clk(clk), .rst_n(rst_n), .wr(in_wr_ok), .wr_data(h_in_wdata),
        .rd(l_in_rd), .full(in_full), .data(l_in_data), .ovr_hit(in_ovr)
    );

    mbox_slot #(.W(W)) u_outbox (
        .clk(clk), .rst_n(rst_n), .wr(l_out_wr), .wr_data(l_out_wdata),
        .rd(h_out_rd), .full(out_full), .data(h_out_data), .ovr_hit(out_ovr)
    );

    ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr(h_ctl_wr),
        .din(h_ctl_irq_en), .en_q(irq_en)
    );

    always_comb begin
        fl_set             = '0;
        fl_clr             = '0;
        fl_set[FLAG_H_OVR] = in_ovr;
        fl_set[FLAG_H_FRZ] = freeze && (h_in_wr || h_ctl_wr);
        fl_set[FLAG_L_OVR] = out_ovr;
        fl_clr[FLAG_H_OVR] = h_stat_rd;
        fl_clr[FLAG_H_FRZ] = h_stat_rd;
        fl_clr[FLAG_L_OVR] = l_stat_rd;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(fl_set[i]), .clr(fl_clr[i]), .q(fl_q[i])
        );
    end

    assign h_ovr_err    = fl_q[FLAG_H_OVR];
    assign h_freeze_err = fl_q[FLAG_H_FRZ];
    assign l_ovr_err    = fl_q[FLAG_L_OVR];

    assign l_in_full   = in_full;
    assign h_in_full   = in_full;
    assign l_irq       = in_full;
    assign l_out_full  = out_full;
    assign h_out_empty = !out_full;
    assign h_irq       = out_full && irq_en;

    a_r8_frozen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && h_in_wr && !l_in_full) |=> !l_in_full);
    a_r8_frozen_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && h_in_wr) |=> h_freeze_err);
    a_r5_host_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_out_empty && h_out_rd && !l_out_wr) |=> (h_out_empty && !h_irq));
    a_r6_host_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && h_in_wr && l_in_full && !l_in_rd) |=> h_ovr_err);
    a_r6_local_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (l_out_wr && l_out_full && !h_out_rd) |=> l_ovr_err);
endmodule

// File: tb/tb_cmd_mailbox_pair.sv
module tb_cmd_mailbox_pair;
    localparam int W = 8;
    localparam int VW = 2 * W + 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freeze = 0, h_in_wr = 0, h_out_rd = 0, h_ctl_wr = 0, h_ctl_irq_en = 0, h_stat_rd = 0;
    logic l_in_rd = 0, l_out_wr = 0, l_stat_rd = 0;
    logic [W-1:0] h_in_wdata = '0, l_out_wdata = '0;
    logic [W-1:0] h_out_data, l_in_data;
    logic h_out_empty, h_in_full, h_ovr_err, h_freeze_err, h_irq, l_in_full, l_irq, l_out_full, l_ovr_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cmd_mailbox_pair #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .h_in_wr(h_in_wr), .h_in_wdata(h_in_wdata), .h_out_rd(h_out_rd),
        .h_out_data(h_out_data), .h_out_empty(h_out_empty), .h_in_full(h_in_full),
        .h_ctl_wr(h_ctl_wr), .h_ctl_irq_en(h_ctl_irq_en), .h_stat_rd(h_stat_rd),
        .h_ovr_err(h_ovr_err), .h_freeze_err(h_freeze_err), .h_irq(h_irq),
        .l_in_rd(l_in_rd), .l_in_data(l_in_data), .l_in_full(l_in_full), .l_irq(l_irq),
        .l_out_wr(l_out_wr), .l_out_wdata(l_out_wdata), .l_out_full(l_out_full),
        .l_stat_rd(l_stat_rd), .l_ovr_err(l_ovr_err)
    );

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } exp_t;
    exp_t sb[$];

    // reference model state
    logic m_in_full = 0, m_out_full = 0, m_en = 0, m_hovr = 0, m_hfrz = 0, m_lovr = 0;
    logic [W-1:0] m_in_data = '0, m_out_data = '0;

    function automatic logic [VW-1:0] act_vec();
        return {l_in_full, h_in_full, l_irq, l_in_data, h_out_empty, l_out_full,
                h_out_data, h_irq, h_ovr_err, h_freeze_err, l_ovr_err};
    endfunction

    function automatic logic [VW-1:0] mdl_vec();
        return {m_in_full, m_in_full, m_in_full, m_in_data, !m_out_full, m_out_full,
                m_out_data, m_out_full && m_en, m_hovr, m_hfrz, m_lovr};
    endfunction

    task automatic check_now(string tag);
        checks++;
        if (act_vec() !== mdl_vec()) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act_vec(), mdl_vec());
        end
    endtask

    // driver: apply one cycle of stimulus, push model prediction
    task automatic step(input logic hw, input logic [W-1:0] hd, input logic hrd,
                        input logic hcw, input logic hen, input logic hsr,
                        input logic lrd, input logic lw, input logic [W-1:0] ld,
                        input logic lsr, input logic frz, input string tag);
        logic iw, ovi, ovo, fz;
        exp_t e;
        @(negedge clk);
        h_in_wr = hw; h_in_wdata = hd; h_out_rd = hrd; h_ctl_wr = hcw; h_ctl_irq_en = hen;
        h_stat_rd = hsr; l_in_rd = lrd; l_out_wr = lw; l_out_wdata = ld; l_stat_rd = lsr;
        freeze = frz;
        iw  = hw && !frz;
        ovi = iw && m_in_full && !lrd;
        ovo = lw && m_out_full && !hrd;
        fz  = frz && (hw || hcw);
        if (iw && (!m_in_full || lrd)) begin m_in_data = hd; m_in_full = 1'b1; end
        else if (m_in_full && lrd) m_in_full = 1'b0;
        if (lw && (!m_out_full || hrd)) begin m_out_data = ld; m_out_full = 1'b1; end
        else if (m_out_full && hrd) m_out_full = 1'b0;
        if (hcw && !frz) m_en = hen;
        m_hovr = ovi ? 1'b1 : (hsr ? 1'b0 : m_hovr);
        m_hfrz = fz  ? 1'b1 : (hsr ? 1'b0 : m_hfrz);
        m_lovr = ovo ? 1'b1 : (lsr ? 1'b0 : m_lovr);
        e.v = mdl_vec();
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (act_vec() !== e.v) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", e.tag, act_vec(), e.v);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 reset state");
        //    hw hd     hrd hcw hen hsr lrd lw ld     lsr frz
        step(1, 8'hA5, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R2 host fills inbox");
        step(1, 8'h3C, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R6 host reject on full inbox");
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R10 h_ovr_err holds");
        step(0, 8'h00, 0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R10 h_stat_rd clears");
        step(1, 8'h96, 0, 0, 0, 0, 1, 0, 8'h00, 0, 0, "R7 inbox refill");
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, 8'h00, 0, 0, "R3 local drains inbox");
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, 8'h00, 0, 0, "R12 read empty inbox");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R12 read empty outbox");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 8'h5A, 0, 0, "R4 local fills outbox irq off");
        step(0, 8'h00, 0, 1, 1, 0, 0, 0, 8'h00, 0, 0, "R11 enable gives h_irq");
        step(0, 8'h00, 1, 0, 0, 0, 0, 1, 8'h77, 0, 0, "R7 outbox refill");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 8'h11, 0, 0, "R6 local reject on full outbox");
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, 1, 0, "R10 l_stat_rd clears");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R5 host drains outbox");
        step(1, 8'hC3, 0, 0, 0, 0, 0, 0, 8'h00, 0, 1, "R8 frozen inbox write");
        step(0, 8'h00, 0, 1, 0, 0, 0, 0, 8'h00, 0, 1, "R9 frozen ctl write");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 8'hE1, 0, 0, "R9 enable kept after freeze");
        step(1, 8'h44, 0, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R10 set wins over clear");
        step(0, 8'h00, 0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R10 freeze flag clears");
        step(0, 8'h00, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, "R11 disable masks h_irq");
        step(0, 8'h00, 1, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R5 host drain irq masked");
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R1 idle");
        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule